// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel. It runs on a count clock in which every clock edge is one tick. It supports six operating modes: a terminal-count interrupt, a retriggerable one-shot, a rate generator, a square-wave generator, and software- and hardware-triggered strobes. A parallel count value and a mode number are captured on a load strobe. After that, the channel produces an output waveform and shows a live count value that a separate bus-side block can sample or latch.

Control-word decoding, byte access, latching and decimal counting belong to that bus-side block; this channel counts in binary only. The gate input may come from an unrelated clock domain. It is synchronized inside the block, and the block detects its rising edges itself. Each mode reacts to the gate in its own way: some modes treat it as a count enable, and others treat a rising edge as a restart trigger.

Top module: `interval_counter`

## Requirements
- R1: A load value of 0 is treated as a period of 65536 ticks. In a one-shot mode, the count reads 0x0000 after the load and 0xFFFF one tick later. In mode 4, the output strobe occurs 65536 ticks after the load.
- R2: In mode 0, the output is low after a load. It goes high once the number of elapsed ticks reaches the loaded value N, and it stays high until the next load.
- R3: In mode 1, the output is high while fewer than N ticks have elapsed since the load or since the last restart. After that it is low.
- R4: In mode 2, the output is high for exactly one tick each time the elapsed ticks reach a nonzero multiple of N. The count shows N minus (elapsed mod N) and reloads on its own.
- R5: In mode 3, the output is high for the first (N+1)/2 ticks of each N-tick period and low for the remaining ticks, so an odd N gives the longer high half. The count shows N minus (2*elapsed mod N), which falls by two per tick.
- R6: In modes 4 and 5, the output is high for exactly one tick, when the elapsed ticks equal N. It does not repeat without a new load or a restart.
- R7: In modes 1, 2, 3 and 5, a rising edge of the gate restarts the period from N. The gate passes through a two-stage synchronizer, so a rise driven before clock edge k takes effect on edge k+2.
- R8: In modes 0 and 4, a low synchronized gate freezes the count and the output, and a high synchronized gate lets counting continue. A gate edge does not restart the period in these modes.
- R9: In modes 0, 1, 4 and 5, the count equals (N minus elapsed ticks) mod 65536, so it keeps wrapping after the terminal point.
- R10: After reset, the mode is 0, the count reads 0x0000 (a period of 65536), the output is low, and the gate is taken as the level set by the GATE_INIT parameter. With the default of 1, counting starts on the first edge without any gate activity.
- R11: A load strobe sampled on a clock edge restarts the period from the new value in any mode. On that same edge the output goes to the mode's initial level: high for modes 1 and 3, low for the others.
- R12: Mode numbers 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; each rising edge is one tick |
| rstN | input | 1 | Active-low reset |
| gateIn | input | 1 | Gate level, asynchronous to clk |
| loadStb | input | 1 | Capture loadVal and mode on this edge |
| loadVal | input | CNT_W | Count value to load (0 means 2^CNT_W) |
| mode | input | 3 | Operating mode number, 0 to 7 |
| outSig | output | 1 | Waveform output of the channel |
| curCount | output | CNT_W | Live count value |

## Verification
Every piece of internal state drives the ports within one tick. A wrong elapsed-tick register shows up on curCount on the next clock, while a stale wrap flag or a stale mode register shows up as an output pulse that is misplaced or missing within one period. A synchronizer with the wrong depth moves the gate restart or gate pause by whole cycles, and the output changes at a different edge than expected. For these reasons the outputs are compared with a tick-exact model on every cycle, under random loads, random modes and random gate activity.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef struct packed {
    logic load;     // capture new count and mode
    logic restart;  // gate-triggered restart of the period
    logic advance;  // one tick of counting
  } strobe_t;

  function automatic logic [2:0] normMode(input logic [2:0] m);
    return (m > 3'd5) ? (m - 3'd4) : m;
  endfunction

  function automatic logic isRetrig(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd5);
  endfunction

  function automatic logic isGated(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd4);
  endfunction

  function automatic logic isPeriodic(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction

endpackage

// File: rtl/ictr_gate_sync.sv
module ictr_gate_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= INIT;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
  import ictr_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic GATE_INIT   = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          gateIn,
  input  logic          loadStb,
  input  logic [2:0]    mode,
  output strobe_t       strb,
  output logic [2:0]    modeReg
);
  logic gateLvl;
  logic gatePrev;
  logic gateRise;

  ictr_gate_sync #(.STAGES(SYNC_STAGES), .INIT(GATE_INIT)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (gateIn),
    .dout (gateLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatePrev <= GATE_INIT;
      modeReg  <= 3'd0;
    end else begin
      gatePrev <= gateLvl;
      if (loadStb) modeReg <= normMode(mode);
    end
  end

  assign gateRise = gateLvl & ~gatePrev;

  always_comb begin
    strb.load    = loadStb;
    strb.restart = gateRise && isRetrig(modeReg);
    strb.advance = isGated(modeReg) ? gateLvl : 1'b1;
  end
endmodule

// File: rtl/ictr_datapath.sv
module ictr_datapath
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [2:0]       modeReg,
  input  logic [CNT_W-1:0] loadVal,
  output logic             outSig,
  output logic [CNT_W-1:0] curCount
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] FULL = EXT_W'(1) << CNT_W;

  logic [EXT_W-1:0] nReg;     // period, 1 .. 2^CNT_W
  logic [EXT_W-1:0] eReg;     // elapsed ticks (mod N when periodic, saturating at N+1 otherwise)
  logic [CNT_W-1:0] cntReg;   // free-running down count for one-shot modes
  logic             wrapped;  // a periodic boundary has been crossed since the last start

  logic [EXT_W-1:0] eNext;
  logic [EXT_W:0]   dbl;
  logic [EXT_W:0]   fold;
  logic [EXT_W-1:0] rateCnt;
  logic [EXT_W-1:0] sqCnt;
  logic [EXT_W-1:0] halfN;

  assign eNext = eReg + EXT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg    <= FULL;
      eReg    <= '0;
      cntReg  <= '0;
      wrapped <= 1'b0;
    end else if (strb.load) begin
      nReg    <= (loadVal == '0) ? FULL : {1'b0, loadVal};
      eReg    <= '0;
      cntReg  <= loadVal;
      wrapped <= 1'b0;
    end else if (strb.restart) begin
      eReg    <= '0;
      cntReg  <= nReg[CNT_W-1:0];
      wrapped <= 1'b0;
    end else if (strb.advance) begin
      cntReg <= cntReg - CNT_W'(1);
      if (isPeriodic(modeReg)) begin
        if (eNext == nReg) begin
          eReg    <= '0;
          wrapped <= 1'b1;
        end else begin
          eReg <= eNext;
        end
      end else if (eReg <= nReg) begin
        eReg <= eNext;
      end
    end
  end

  // square-wave view: twice the phase, folded back into one period
  assign dbl     = {eReg, 1'b0};
  assign fold    = (dbl >= {1'b0, nReg}) ? (dbl - {1'b0, nReg}) : dbl;
  assign sqCnt   = nReg - fold[EXT_W-1:0];
  assign rateCnt = nReg - eReg;
  assign halfN   = (nReg + EXT_W'(1)) >> 1;

  always_comb begin
    unique case (modeReg)
      3'd0:    outSig = (eReg >= nReg);
      3'd1:    outSig = (eReg < nReg);
      3'd2:    outSig = wrapped && (eReg == '0);
      3'd3:    outSig = (eReg < halfN);
      default: outSig = (eReg == nReg);
    endcase
  end

  always_comb begin
    unique case (modeReg)
      3'd2:    curCount = rateCnt[CNT_W-1:0];
      3'd3:    curCount = sqCnt[CNT_W-1:0];
      default: curCount = cntReg;
    endcase
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ictr_pkg::*;
#(
  parameter int   CNT_W       = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic GATE_INIT   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [2:0]       mode,
  output logic             outSig,
  output logic [CNT_W-1:0] curCount
);
  strobe_t    strb;
  logic [2:0] modeReg;

  ictr_ctrl #(.SYNC_STAGES(SYNC_STAGES), .GATE_INIT(GATE_INIT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .gateIn  (gateIn),
    .loadStb (loadStb),
    .mode    (mode),
    .strb    (strb),
    .modeReg (modeReg)
  );

  ictr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeReg  (modeReg),
    .loadVal  (loadVal),
    .outSig   (outSig),
    .curCount (curCount)
  );
endmodule

// File: rtl/ictr_checker.sv
module ictr_checker
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadStb,
  input logic [2:0]       mode,
  input logic             outSig,
  input logic [CNT_W-1:0] curCount,
  input logic [2:0]       modeReg,
  input strobe_t          strb
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  AST_LOAD_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && (mode == 3'd1 || mode == 3'd3 || mode == 3'd7)) |=> outSig); // R11

  AST_LOAD_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !(mode == 3'd1 || mode == 3'd3 || mode == 3'd7)) |=> !outSig); // R11

  AST_TERMINAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == 3'd0 && outSig && !loadStb) |=> outSig); // R2

  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ((modeReg == 3'd4 || modeReg == 3'd5) && outSig && strb.advance && !loadStb) |=> !outSig); // R6

  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (armed && isGated(modeReg) && !strb.advance && !loadStb)
      |=> ($stable(curCount) && $stable(outSig))); // R8

  AST_ONESHOT_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !isPeriodic(modeReg) && strb.advance && !strb.restart && !loadStb)
      |=> (curCount == $past(curCount) - CNT_W'(1))); // R9
endmodule

bind interval_counter ictr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadStb  (loadStb),
  .mode     (mode),
  .outSig   (outSig),
  .curCount (curCount),
  .modeReg  (modeReg),
  .strb     (strb)
);

// File: tb/sim_interval_counter.sv
`timescale 1ns/100ps
module sim_interval_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        gateIn = 1'b1;
  logic        loadStb = 1'b0;
  logic [15:0] loadVal = 16'd0;
  logic [2:0]  mode = 3'd0;
  logic        outSig;
  logic [15:0] curCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  interval_counter u0 (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .loadStb(loadStb),
    .loadVal(loadVal), .mode(mode), .outSig(outSig), .curCount(curCount)
  );

  // reference model in elapsed-tick terms
  int   nPer = 65536;
  int   elap = 0;
  int   md = 0;
  bit   g1 = 1, g2 = 1, g3 = 1;

  always @(posedge clk) begin
    bit rise, en;
    if (!rstN) begin
      nPer = 65536; elap = 0; md = 0; g1 = 1; g2 = 1; g3 = 1;
    end else begin
      rise = g2 && !g3;
      en   = g2;
      if (loadStb) begin
        nPer = (loadVal == 16'd0) ? 65536 : int'(loadVal);
        elap = 0;
        md   = (mode > 3'd5) ? int'(mode) - 4 : int'(mode);
      end else if (rise && (md == 1 || md == 2 || md == 3 || md == 5)) begin
        elap = 0;
      end else if (!(md == 0 || md == 4) || en) begin
        elap = elap + 1;
      end
      g3 = g2; g2 = g1; g1 = gateIn;
    end
  end

  function automatic bit expOut(int m, int e, int n);
    case (m)
      0: return e >= n;
      1: return e < n;
      2: return (e > 0) && (e % n == 0);
      3: return (e % n) < ((n + 1) / 2);
      default: return e == n;
    endcase
  endfunction

  function automatic logic [15:0] expCnt(int m, int e, int n);
    int v;
    case (m)
      2: v = n - (e % n);
      3: v = n - ((2 * e) % n);
      default: v = n - e;
    endcase
    return v[15:0];
  endfunction

  function automatic string modeTag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag);
    bit          eo;
    logic [15:0] ec;
    eo = expOut(md, elap, nPer);
    ec = expCnt(md, elap, nPer);
    total++;
    if (outSig !== eo || curCount !== ec) begin
      bad++;
      $display("FAIL %s: out=%0b cnt=%0h expected out=%0b cnt=%0h (mode %0d elapsed %0d)",
               tag, outSig, curCount, eo, ec, md, elap);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic doLoad(logic [2:0] m, logic [15:0] v, string tag);
    loadStb = 1'b1; mode = m; loadVal = v;
    @(negedge clk);
    check(tag);
    loadStb = 1'b0;
  endtask

  initial begin
    #(5ns * 190000);
    bad++; total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10");            // reset state: mode 0, count 0, out low
    rstN = 1'b1;
    run(1, "R10");           // gate defaults high: count already moving -> 0xFFFF
    run(2, "R1");

    doLoad(3'd0, 16'd5, "R11"); run(9, "R2");
    doLoad(3'd1, 16'd4, "R11"); run(7, "R3");
    doLoad(3'd2, 16'd3, "R11"); run(10, "R4");
    doLoad(3'd2, 16'd1, "R4");  run(4, "R4");
    doLoad(3'd3, 16'd5, "R11"); run(12, "R5");
    doLoad(3'd3, 16'd6, "R5");  run(13, "R5");
    doLoad(3'd4, 16'd3, "R11"); run(8, "R6");
    doLoad(3'd5, 16'd3, "R6");  run(8, "R6");
    doLoad(3'd6, 16'd4, "R12"); run(10, "R12");
    doLoad(3'd7, 16'd3, "R12"); run(8, "R12");
    doLoad(3'd1, 16'd0, "R9");  run(3, "R9");

    // gate restart in retriggerable modes
    for (int m = 1; m <= 5; m++) begin
      if (m == 4) continue;
      doLoad(3'(m), 16'd6, "R7");
      run(3, "R7");
      gateIn = 1'b0; run(3, "R7");
      gateIn = 1'b1; run(9, "R7");
    end

    // gate pause in gated modes
    doLoad(3'd0, 16'd6, "R8"); run(2, "R8");
    gateIn = 1'b0; run(5, "R8");
    gateIn = 1'b1; run(9, "R8");
    doLoad(3'd4, 16'd4, "R8"); run(2, "R8");
    gateIn = 1'b0; run(4, "R8");
    gateIn = 1'b1; run(6, "R8");

    // zero load = 65536-tick period, strobe at the end
    doLoad(3'd4, 16'd0, "R1");
    run(65540, "R1");

    // random mix of loads, modes and gate activity
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 5) begin
        loadStb = 1'b1;
        mode    = 3'($urandom % 8);
        loadVal = 16'(($urandom % 12));
      end else begin
        loadStb = 1'b0;
      end
      if (r >= 90) gateIn = ~gateIn;
      @(negedge clk);
      check(loadStb ? "R11" : modeTag(md));
    end
    loadStb = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule